// File: doc/BRIEF.md
# Fly-by DMA Bus Takeover Sequencer

This block is a one-channel transfer engine that carries bytes from a peripheral straight into memory while the processor stands off the bus. When the peripheral signals that it holds data and the channel is not masked, the engine asks the processor for the bus and waits for its grant. Only then does it drive a memory address, acknowledge the peripheral, and pulse the memory-write and I/O-read strobes together. The byte therefore moves in one bus cycle and never passes through the engine.

After each transfer the engine steps its address up by one and its count down by one. The count holds the number of transfers minus one. A transfer made while the count is zero is the last one: the count wraps to all ones, a terminal-count pulse is raised, and the bus is handed back. The bus is also handed back when, at the end of a transfer, the request has gone or the channel has been masked. A small write-only register port loads the start address, the count and the mask bit.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: After reset the hold request, bus enable, acknowledge, both strobes, terminal count and address output are all 0, the channel is masked, and the address and count registers hold 0.
- R2: A request while the channel is masked (mask write with cfg_sel_i = 2, bit 0 = 1) never raises the hold request.
- R3: An unmasked request seen in idle raises the hold request on the next clock edge, and the hold request stays high until the final transfer finishes and the bus is released.
- R4: No bus enable, acknowledge or strobe is driven until a hold acknowledge has been sampled, however long the grant takes.
- R5: Each transfer asserts the acknowledge, memory-write and I/O-read together for exactly 2 clocks, with bus enable high and the current address on the address output.
- R6: After each transfer the address register goes up by 1 and the count register goes down by 1, so successive transfers use consecutive addresses.
- R7: A transfer made while the count is 0 is the last: tc_o is high for one clock in the release cycle that follows it, and a count of N gives N+1 transfers.
- R8: If the request is low, or the channel is masked, when a transfer ends, the engine releases the bus after that transfer without raising tc_o.
- R9: The bus enable drops one clock before the hold request drops.
- R10: Writes to the address (cfg_sel_i = 0) or count (cfg_sel_i = 1) are ignored while the engine is not idle; mask writes take effect at any time.
- R11: The address output reads 0 whenever bus enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 address, 1 count, 2 mask, 3 none |
| cfg_wdata_i | input | 20 | Register write data |
| dreq_i | input | 1 | Peripheral transfer request |
| dack_o | output | 1 | Acknowledge to the peripheral |
| hold_req_o | output | 1 | Bus request to the processor |
| hold_ack_i | input | 1 | Bus grant from the processor |
| bus_en_o | output | 1 | Engine is driving the bus |
| mem_addr_o | output | 20 | Memory address |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| tc_o | output | 1 | Terminal count pulse |

## Verification
The hardest case to reach is the decision at the end of a transfer, where terminal count, a dropped request and a mask write landing in the same cycle all compete to end the burst. Directed bursts drop the request right after the first strobe and run a small count to its wrap. A long random phase then toggles request, grant, mask and register writes at every clock so that these events fall on every state. A cycle-level model in the bench, built from the requirements, predicts every output on every clock.

// File: rtl/dma_flyby_pkg.sv
package dma_flyby_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_HOLD,
    ST_WAIT_HLDA,
    ST_XFER,
    ST_NEXT,
    ST_RELEASE
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/dma_flyby_regs.sv
module dma_flyby_regs
  import dma_flyby_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int CNT_W   = 16,
  parameter int WDATA_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  cfg_sel_e           sel_i,
  input  logic [WDATA_W-1:0] wdata_i,
  input  logic               busy_i,
  input  logic               step_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               mask_o,
  output logic               cnt_zero_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_W'(1);
      cnt_q  <= cnt_q - CNT_W'(1);
    end else if (we_i && !busy_i) begin
      if (sel_i == SEL_ADDR)  addr_q <= wdata_i[ADDR_W-1:0];
      if (sel_i == SEL_COUNT) cnt_q  <= wdata_i[CNT_W-1:0];
    end
  end

  // mask stays writable during a burst so software can cut it short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mask_q <= 1'b1;
    else if (we_i && sel_i == SEL_MASK)  mask_q <= wdata_i[0];
  end

  assign addr_o     = addr_q;
  assign mask_o     = mask_q;
  assign cnt_zero_o = (cnt_q == '0);

endmodule

// File: rtl/dma_flyby_seq.sv
module dma_flyby_seq
  import dma_flyby_pkg::*;
#(
  parameter int XFER_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_ok_i,
  input  logic       hold_ack_i,
  input  logic       cnt_zero_i,
  output seq_state_e state_o,
  output logic       step_o,
  output logic       tc_o
);

  localparam int BW = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(XFER_CYC - 1);

  seq_state_e state_q, state_d;
  logic [BW-1:0] beat_q, beat_d;
  logic tc_q, tc_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    case (state_q)
      ST_IDLE:      if (req_ok_i) state_d = ST_REQ_HOLD;
      ST_REQ_HOLD:  state_d = ST_WAIT_HLDA;
      ST_WAIT_HLDA: if (hold_ack_i) begin
                      state_d = ST_XFER;
                      beat_d  = '0;
                    end
      ST_XFER:      if (beat_q == LAST_BEAT) state_d = ST_NEXT;
                    else beat_d = beat_q + BW'(1);
      ST_NEXT:      if (cnt_zero_i || !req_ok_i) state_d = ST_RELEASE;
                    else begin
                      state_d = ST_XFER;
                      beat_d  = '0;
                    end
      ST_RELEASE:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // count wraps on the step taken in ST_NEXT; flag it for the release cycle
  assign tc_d = (state_q == ST_NEXT) && cnt_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      tc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      tc_q    <= tc_d;
    end
  end

  assign state_o = state_q;
  assign step_o  = (state_q == ST_NEXT);
  assign tc_o    = tc_q;

endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl
  import dma_flyby_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CNT_W    = 16,
  parameter int WDATA_W  = 20,
  parameter int XFER_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [WDATA_W-1:0] cfg_wdata_i,
  input  logic               dreq_i,
  output logic               dack_o,
  output logic               hold_req_o,
  input  logic               hold_ack_i,
  output logic               bus_en_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_wr_o,
  output logic               io_rd_o,
  output logic               tc_o
);

  seq_state_e        state;
  logic              step, cnt_zero, mask, req_ok, busy, strobe;
  logic [ADDR_W-1:0] addr;

  assign req_ok = dreq_i && !mask;
  assign busy   = (state != ST_IDLE);

  dma_flyby_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WDATA_W(WDATA_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_e'(cfg_sel_i)),
    .wdata_i   (cfg_wdata_i),
    .busy_i    (busy),
    .step_i    (step),
    .addr_o    (addr),
    .mask_o    (mask),
    .cnt_zero_o(cnt_zero)
  );

  dma_flyby_seq #(
    .XFER_CYC(XFER_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_ok_i  (req_ok),
    .hold_ack_i(hold_ack_i),
    .cnt_zero_i(cnt_zero),
    .state_o   (state),
    .step_o    (step),
    .tc_o      (tc_o)
  );

  assign strobe     = (state == ST_XFER);
  assign hold_req_o = busy;
  assign bus_en_o   = (state == ST_XFER) || (state == ST_NEXT);
  assign dack_o     = strobe;
  assign mem_wr_o   = strobe;
  assign io_rd_o    = strobe;
  assign mem_addr_o = bus_en_o ? addr : '0;

endmodule

// File: rtl/dma_flyby_ctrl_chk.sv
module dma_flyby_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dreq_i,
  input logic              hold_ack_i,
  input logic              hold_req_o,
  input logic              bus_en_o,
  input logic              dack_o,
  input logic              mem_wr_o,
  input logic              io_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              tc_o
);

  a_r2_hold_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_req_o) |-> $past(dreq_i));

  a_r4_drive_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_en_o) |-> $past(hold_ack_i));

  a_r4_strobe_inside_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o || mem_wr_o || io_rd_o) |-> (bus_en_o && hold_req_o));

  a_r5_strobes_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o == io_rd_o) && (io_rd_o == dack_o));

  a_r5_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !$past(mem_wr_o)) |=> mem_wr_o);

  a_r5_second_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && $past(mem_wr_o)) |=> !mem_wr_o);

  a_r5_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && $past(mem_wr_o)) |-> $stable(mem_addr_o));

  a_r7_tc_in_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (hold_req_o && !bus_en_o));

  a_r7_tc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> (!tc_o && !hold_req_o));

  a_r9_release_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_req_o) |-> (!bus_en_o && !$past(bus_en_o)));

  a_r11_addr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_o |-> (mem_addr_o == '0));

endmodule

bind dma_flyby_ctrl dma_flyby_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dreq_i    (dreq_i),
  .hold_ack_i(hold_ack_i),
  .hold_req_o(hold_req_o),
  .bus_en_o  (bus_en_o),
  .dack_o    (dack_o),
  .mem_wr_o  (mem_wr_o),
  .io_rd_o   (io_rd_o),
  .mem_addr_o(mem_addr_o),
  .tc_o      (tc_o)
);

// File: tb/dma_flyby_ctrl_tb_top.sv
module dma_flyby_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int CW = 16;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd3;
  logic [AW-1:0] cfg_wdata = '0;
  logic          dreq = 1'b0;
  logic          hold_ack = 1'b0;
  logic          dack, hold_req, bus_en, mem_wr, io_rd, tc;
  logic [AW-1:0] mem_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_flyby_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .dreq_i(dreq), .dack_o(dack), .hold_req_o(hold_req), .hold_ack_i(hold_ack),
    .bus_en_o(bus_en), .mem_addr_o(mem_addr), .mem_wr_o(mem_wr), .io_rd_o(io_rd),
    .tc_o(tc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model: 0 idle 1 hold-req 2 wait-grant 3 transfer 4 step 5 release
  int            m_st;
  int            m_beat;
  logic [AW-1:0] m_addr;
  logic [CW-1:0] m_cnt;
  logic          m_mask, m_tc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_beat <= 0; m_addr <= '0; m_cnt <= '0; m_mask <= 1'b1; m_tc <= 1'b0;
    end else begin
      m_tc <= 1'b0;
      case (m_st)
        0: if (dreq && !m_mask) m_st <= 1;
        1: m_st <= 2;
        2: if (hold_ack) begin m_st <= 3; m_beat <= 0; end
        3: if (m_beat == 1) m_st <= 4; else m_beat <= m_beat + 1;
        4: begin
          m_addr <= m_addr + 1'b1;
          m_cnt  <= m_cnt - 1'b1;
          m_tc   <= (m_cnt == 0);
          if (m_cnt == 0 || !dreq || m_mask) m_st <= 5;
          else begin m_st <= 3; m_beat <= 0; end
        end
        default: m_st <= 0;
      endcase
      if (cfg_we && cfg_sel == 2'd2) m_mask <= cfg_wdata[0];
      if (cfg_we && m_st == 0 && cfg_sel == 2'd0) m_addr <= cfg_wdata;
      if (cfg_we && m_st == 0 && cfg_sel == 2'd1) m_cnt <= cfg_wdata[CW-1:0];
    end
  end

  // per-cycle comparison and transfer log
  logic [AW-1:0] log_addr [64];
  int            log_n = 0;
  int            tc_n = 0;
  logic          prev_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_bus, exp_stb;
      exp_bus = (m_st == 3) || (m_st == 4);
      exp_stb = (m_st == 3);
      chk(hold_req == (m_st != 0), "R3 R9 hold_req", 32'(hold_req), 32'(m_st != 0));
      chk(bus_en == exp_bus, "R4 R9 bus_en", 32'(bus_en), 32'(exp_bus));
      chk({dack, mem_wr, io_rd} == {3{exp_stb}}, "R5 strobes", 32'({dack, mem_wr, io_rd}), 32'({3{exp_stb}}));
      chk(mem_addr == (exp_bus ? m_addr : '0), "R6 R11 mem_addr", 32'(mem_addr), 32'(exp_bus ? m_addr : '0));
      chk(tc == m_tc, "R7 tc", 32'(tc), 32'(m_tc));
      if (mem_wr && !prev_wr && log_n < 64) begin
        log_addr[log_n] = mem_addr;
        log_n++;
      end
      if (tc) tc_n++;
      prev_wr = mem_wr;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20 && !hold_req; i++) @(negedge clk);
    for (int i = 0; i < 2000 && hold_req; i++) @(negedge clk);
  endtask

  task automatic wait_first_wr();
    for (int i = 0; i < 50 && !mem_wr; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk({hold_req, bus_en, dack, mem_wr, io_rd, tc} == 6'b0, "R1 outputs after reset",
        32'({hold_req, bus_en, dack, mem_wr, io_rd, tc}), 32'd0);
    chk(mem_addr == '0, "R1 address after reset", 32'(mem_addr), 32'd0);

    // R1/R2: masked by default, request ignored
    dreq = 1'b1; hold_ack = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(hold_req == 1'b0, "R2 masked request", 32'(hold_req), 32'd0);
    end
    dreq = 1'b0;

    // R6/R7: count 2 gives three transfers then terminal count
    cfg_write(2'd0, 20'h12340);
    cfg_write(2'd1, 20'd2);
    cfg_write(2'd2, 20'd0);
    log_n = 0; tc_n = 0;
    dreq = 1'b1;
    wait_idle();
    dreq = 1'b0;
    chk(log_n == 3, "R7 transfer count", 32'(log_n), 32'd3);
    for (int i = 0; i < 3; i++)
      chk(log_addr[i] == 20'h12340 + 20'(i), "R6 address sequence", 32'(log_addr[i]), 32'(20'h12340 + 20'(i)));
    chk(tc_n == 1, "R7 terminal pulse", 32'(tc_n), 32'd1);

    // R8/R10: drop request after first strobe, address write during burst ignored
    cfg_write(2'd0, 20'h00100);
    cfg_write(2'd1, 20'd10);
    log_n = 0; tc_n = 0;
    dreq = 1'b1;
    wait_first_wr();
    dreq = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 20'h00005;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    wait_idle();
    chk(log_n == 1, "R8 single transfer on drop", 32'(log_n), 32'd1);
    chk(tc_n == 0, "R8 no tc on drop", 32'(tc_n), 32'd0);
    dreq = 1'b1;
    wait_first_wr();
    dreq = 1'b0;
    wait_idle();
    chk(log_n == 2 && log_addr[1] == 20'h00101, "R10 busy address write ignored",
        32'(log_addr[1]), 32'h00101);

    // R4: slow grant holds off the bus
    hold_ack = 1'b0;
    dreq = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(bus_en == 1'b0 && hold_req == 1'b1, "R4 no drive before grant", 32'({hold_req, bus_en}), 32'b10);
    end
    dreq = 1'b0;
    hold_ack = 1'b1;
    wait_idle();

    // R8: mask written mid-burst ends it
    cfg_write(2'd1, 20'd20);
    log_n = 0;
    dreq = 1'b1;
    wait_first_wr();
    cfg_write(2'd2, 20'd1);
    wait_idle();
    chk(log_n == 1, "R8 mask ends burst", 32'(log_n), 32'd1);
    dreq = 1'b0;
    cfg_write(2'd2, 20'd0);

    // random phase, checked cycle by cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      dreq     = ($urandom % 5) != 0;
      hold_ack = ($urandom % 3) != 0;
      cfg_we   = ($urandom % 6) == 0;
      cfg_sel  = 2'($urandom % 4);
      if (cfg_sel == 2'd1)      cfg_wdata = 20'($urandom % 5);
      else if (cfg_sel == 2'd2) cfg_wdata = 20'(($urandom % 4) == 0);
      else                      cfg_wdata = 20'($urandom);
    end
    @(negedge clk);
    cfg_we = 1'b0; dreq = 1'b0; hold_ack = 1'b1;
    repeat (20) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule